// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked on-chip request stream to an external asynchronous static RAM organised as 131,072 bytes. Each request carries a read/write select, a 17-bit word address and, for writes, one data byte. The controller turns the request into the external pin sequence: two chip selects of opposite polarity, a write strobe, an output enable and a split tristate data bus (drive value, drive enable, sampled input). Every analog timing minimum of the memory is converted into a whole number of clock cycles at elaboration time, always rounding up.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and its fields stable until that edge. While an access is in progress `req_ready` stays low, and any request fields presented in that time are ignored. Read data comes back as a single-cycle `rsp_valid` pulse with `rsp_rdata`. This path has no back-pressure, so the consumer must take the byte in that cycle. `rsp_rdata` keeps its value until the next read completes.

A write takes one address/select setup cycle. It then takes a write-strobe pulse whose length covers the pulse minimum and also the memory's output-release delay plus the data setup. A hold cycle with the strobe high and the data still driven follows. A read holds output enable low for the access count, then spends a turnaround period with output enable high before the controller takes a new request.

Top module: `asram_bridge`

## Requirements
- R1: While `req_ready` is high the memory is parked. That means `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. After reset `req_ready`=1 and `rsp_valid`=0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge until the access ends, and request fields presented while `req_ready` is 0 have no effect.
- R3: During a read access `mem_oe_n`=0, `mem_we_n`=1, `mem_cs_n`=0 and `mem_cs`=1. Each of these lasts exactly RD cycles, where RD = max(ceil(tAA/Tclk), ceil(tOE/Tclk)). `mem_dq_i` is sampled at the edge that ends the last access cycle.
- R4: `rsp_valid` is high for exactly one cycle. It rises RD cycles after the accept edge, with `rsp_rdata` holding the sampled byte. `rsp_rdata` keeps that byte until the next read.
- R5: After `mem_oe_n` returns high, `req_ready` stays low for TURN = ceil(tOHZ/Tclk) further cycles. A read therefore returns to ready RD+TURN cycles after the accept edge.
- R6: In a write, address and selects are valid one cycle before `mem_we_n` falls. `mem_oe_n` stays 1 for the whole write.
- R7: `mem_we_n` is low for WP cycles, where WP = max(ceil(tWP/Tclk), ceil(tWHZ/Tclk)+ceil(tDS/Tclk), ceil(tAW/Tclk)−1, 1). The bus is not driven during the first ceil(tWHZ/Tclk) cycles of the pulse.
- R8: The write byte is driven for at least ceil(tDS/Tclk) cycles before `mem_we_n` rises. Address and data do not change while the bus is driven.
- R9: `mem_we_n` rises one cycle before the bus is released and the selects drop. A write returns to ready 2+WP cycles after the accept edge, and it produces no `rsp_valid`.
- R10: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R11: Each cycle count is ceil(time/clock period) with a minimum of 1, computed from picosecond parameters. With defaults (10 ns clock) RD=1, TURN=1, WP=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Word address |
| req_wdata | input | DATA_W (8) | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W (8) | Read byte, held until next read |
| mem_addr | output | ADDR_W (17) | Memory address pins |
| mem_cs_n | output | 1 | Low-active chip select |
| mem_cs | output | 1 | High-active chip select |
| mem_we_n | output | 1 | Write strobe, low-active |
| mem_oe_n | output | 1 | Output enable, low-active |
| mem_dq_o | output | DATA_W (8) | Data bus drive value |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W (8) | Data bus sampled value |

## Verification
The bench's memory model returns a decoy byte whenever output enable is not truly active. A controller that captured one edge early would therefore return 0x5A rather than the stored byte. Time-stamped monitors measure, in nanoseconds, the strobe width, the gap between strobe fall and bus drive, and the data setup before strobe rise. These catch a design that drives into the memory's still-active outputs or shortens the pulse. The bench also alters the request fields while the controller is busy and reads both addresses back, which exposes a design that re-latches or double-issues. The lowest and highest addresses and back-to-back write/read to one location are also exercised.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RACC = 3'd1,
    ST_RREL = 3'd2,
    ST_WSET = 3'd3,
    ST_WPUL = 3'd4,
    ST_WHLD = 3'd5
  } seq_st_t;

  // Cycles needed to cover t_ps at clk_ps per cycle, rounded up, never below one.
  function automatic int unsigned ps2cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_tmr.sv
`timescale 1ns/1ps
module asram_tmr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             done
);

  always_comb begin
    if (load)
      cnt_nx = load_val;
    else if (cnt != '0)
      cnt_nx = cnt - 1'b1;
    else
      cnt_nx = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else
      cnt <= cnt_nx;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned RD_CYC   = 1,
  parameter int unsigned TURN_CYC = 1,
  parameter int unsigned WPUL_CYC = 2,
  parameter int unsigned HZW_CYC  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic capture,
  output logic o_sel,
  output logic o_we_n,
  output logic o_oe_n,
  output logic o_drv,
  output logic o_idle
);

  localparam int unsigned MAXC  = umax(umax(RD_CYC, TURN_CYC), WPUL_CYC);
  localparam int          CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CNT_W-1:0] L_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] L_TURN = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] L_WPUL = CNT_W'(WPUL_CYC - 1);
  // Pulse cycles with count at or below this value may drive the bus.
  localparam logic [CNT_W-1:0] DRV_AT = CNT_W'(WPUL_CYC - 1 - HZW_CYC);

  seq_st_t          st, nxt;
  logic             load;
  logic [CNT_W-1:0] lval;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic             done;

  asram_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (lval),
    .cnt      (cnt),
    .cnt_nx   (cnt_nx),
    .done     (done)
  );

  always_comb begin
    nxt  = st;
    load = 1'b0;
    lval = '0;
    unique case (st)
      ST_IDLE: if (start) begin
        nxt  = start_wr ? ST_WSET : ST_RACC;
        load = 1'b1;
        lval = start_wr ? '0 : L_RD;
      end
      ST_RACC: if (done) begin
        nxt  = ST_RREL;
        load = 1'b1;
        lval = L_TURN;
      end
      ST_RREL: if (done) nxt = ST_IDLE;
      ST_WSET: if (done) begin
        nxt  = ST_WPUL;
        load = 1'b1;
        lval = L_WPUL;
      end
      ST_WPUL: if (done) begin
        nxt  = ST_WHLD;
        load = 1'b1;
        lval = '0;
      end
      ST_WHLD: if (done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign capture = (st == ST_RACC) && done;

  // Pin strobes come straight from flops so the memory never sees a decode glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      o_sel  <= 1'b0;
      o_we_n <= 1'b1;
      o_oe_n <= 1'b1;
      o_drv  <= 1'b0;
      o_idle <= 1'b1;
    end else begin
      st     <= nxt;
      o_sel  <= (nxt == ST_RACC) || (nxt == ST_WSET) || (nxt == ST_WPUL) || (nxt == ST_WHLD);
      o_we_n <= (nxt != ST_WPUL);
      o_oe_n <= (nxt != ST_RACC);
      o_drv  <= ((nxt == ST_WPUL) && (cnt_nx <= DRV_AT)) || (nxt == ST_WHLD);
      o_idle <= (nxt == ST_IDLE);
    end
  end

endmodule

// File: rtl/asram_bridge.sv
`timescale 1ns/1ps
module asram_bridge
  import asram_pkg::*;
#(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 8,
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_AA_PS  = 10000,
  parameter int unsigned T_OE_PS  = 6000,
  parameter int unsigned T_OHZ_PS = 6000,
  parameter int unsigned T_WP_PS  = 8000,
  parameter int unsigned T_DS_PS  = 7000,
  parameter int unsigned T_WHZ_PS = 7000,
  parameter int unsigned T_AW_PS  = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int unsigned RD_CYC   = umax(ps2cyc(T_AA_PS, CLK_PS), ps2cyc(T_OE_PS, CLK_PS));
  localparam int unsigned TURN_CYC = ps2cyc(T_OHZ_PS, CLK_PS);
  localparam int unsigned HZW_CYC  = ps2cyc(T_WHZ_PS, CLK_PS);
  localparam int unsigned DS_CYC   = ps2cyc(T_DS_PS, CLK_PS);
  localparam int unsigned WP_CYC   = ps2cyc(T_WP_PS, CLK_PS);
  // The setup cycle already counts toward address-valid-to-end-of-write.
  localparam int unsigned AW_CYC   = umax(ps2cyc(T_AW_PS, CLK_PS), 2) - 1;
  localparam int unsigned WPUL_CYC = umax(umax(WP_CYC, HZW_CYC + DS_CYC), AW_CYC);

  logic              accept;
  logic              capture;
  logic              sel;
  logic              idle;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  assign accept = req_valid && idle;

  asram_seq #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .WPUL_CYC (WPUL_CYC),
    .HZW_CYC  (HZW_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_wr (req_write),
    .capture  (capture),
    .o_sel    (sel),
    .o_we_n   (mem_we_n),
    .o_oe_n   (mem_oe_n),
    .o_drv    (mem_dq_oe),
    .o_idle   (idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else if (accept) begin
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture)
        rsp_rdata <= mem_dq_i;
    end
  end

  assign req_ready = idle;
  assign mem_addr  = lat_addr;
  assign mem_dq_o  = lat_wdata;
  assign mem_cs_n  = ~sel;
  assign mem_cs    = sel;

endmodule

// File: rtl/asram_chk.sv
`timescale 1ns/1ps
module asram_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  p_idle_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_read_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n && mem_cs));

  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_oe_n && !req_ready));

  p_write_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_cs_n && mem_cs));

  p_we_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_cs_n) && $stable(mem_addr)));

  p_fall_nodrv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);

  p_rise_drv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($past(mem_dq_oe) && mem_dq_oe));

  p_drive_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> ($stable(mem_dq_o) && $stable(mem_addr)));

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> (!mem_dq_oe && mem_cs_n));

  p_no_contend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

endmodule

bind asram_bridge asram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_cs    (mem_cs),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_asram_bridge.sv
`timescale 1ns/1ps
module sim_asram_bridge;

  localparam int  CLK_NS = 10;
  localparam real T_AA   = 10.0;
  localparam real T_OE   = 6.0;
  localparam real T_OHZ  = 6.0;
  localparam real T_WP   = 8.0;
  localparam real T_DS   = 7.0;
  localparam real T_WHZ  = 7.0;
  localparam real T_AW   = 10.0;
  localparam real EPS    = 0.001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2.0) clk = ~clk;

  asram_bridge #(.CLK_PS(CLK_NS * 1000)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Expected cycle counts derived from the timing numbers (R11).
  function automatic int cyc(input real t);
    int n;
    n = int'($ceil(t / CLK_NS));
    return (n < 1) ? 1 : n;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int E_RD   = (int'($ceil(T_AA / CLK_NS)) > int'($ceil(T_OE / CLK_NS))) ?
                          int'($ceil(T_AA / CLK_NS)) : int'($ceil(T_OE / CLK_NS));
  int e_turn, e_wpul;

  // Memory model: only two 256-byte windows are ever addressed.
  logic [7:0] smem [512];
  logic [7:0] refm [512];
  function automatic int idx(input logic [16:0] a);
    return int'({a[16], a[7:0]});
  endfunction

  always_comb begin
    if (!mem_cs_n && mem_cs && mem_we_n && !mem_oe_n)
      mem_dq_i = smem[idx(mem_addr)];
    else
      mem_dq_i = 8'h5A;
  end

  always @(posedge mem_we_n)
    if (rst_n && !mem_cs_n && mem_cs && mem_dq_oe)
      smem[idx(mem_addr)] = mem_dq_o;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Analog timing monitors, measured in ns.
  real t_cs_on = 0.0, t_we_fall = 0.0, t_we_rise = 0.0, t_drv_on = 0.0, t_oe_on = 0.0;

  always @(negedge mem_cs_n) t_cs_on = $realtime;
  always @(negedge mem_oe_n) t_oe_on = $realtime;

  always @(negedge mem_we_n) if (rst_n) begin
    t_we_fall = $realtime;
    chk(($realtime - t_cs_on) >= CLK_NS - EPS, "R6", "select lead before strobe fall ns",
        int'($realtime - t_cs_on), CLK_NS);
    chk(mem_oe_n == 1'b1, "R6", "oe_n during write", int'(mem_oe_n), 1);
  end

  always @(posedge mem_dq_oe) if (rst_n) begin
    t_drv_on = $realtime;
    chk(!mem_we_n && ($realtime - t_we_fall) >= T_WHZ - EPS, "R7", "strobe fall to drive ns",
        int'($realtime - t_we_fall), int'(T_WHZ));
  end

  always @(posedge mem_we_n) if (rst_n && t_we_fall > 0.0) begin
    t_we_rise = $realtime;
    chk(($realtime - t_we_fall) >= T_WP - EPS, "R7", "strobe width ns",
        int'($realtime - t_we_fall), int'(T_WP));
    chk(mem_dq_oe && ($realtime - t_drv_on) >= T_DS - EPS, "R8", "data setup ns",
        int'($realtime - t_drv_on), int'(T_DS));
  end

  always @(negedge mem_dq_oe) if (rst_n)
    chk(($realtime - t_we_rise) >= CLK_NS - EPS, "R9", "strobe rise to release ns",
        int'($realtime - t_we_rise), CLK_NS);

  always @(posedge mem_oe_n) if (rst_n && t_oe_on > 0.0)
    chk(($realtime - t_oe_on) >= imax(int'(T_AA), int'(T_OE)) - EPS, "R3", "oe low time ns",
        int'($realtime - t_oe_on), imax(int'(T_AA), int'(T_OE)));

  // Per-cycle pin monitors sampled mid-cycle.
  int bad_park = 0, bad_cont = 0, bad_stab = 0;
  logic        prev_sel = 1'b0, prev_drv = 1'b0;
  logic [16:0] prev_addr = '0;
  logic [7:0]  prev_dout = '0;
  always @(negedge clk) if (rst_n) begin
    if (req_ready && !(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe)) bad_park++;
    if (mem_dq_oe && !mem_oe_n) bad_cont++;
    if (!mem_cs_n && prev_sel && mem_addr != prev_addr) bad_stab++;
    if (mem_dq_oe && prev_drv && mem_dq_o != prev_dout) bad_stab++;
    prev_sel  = !mem_cs_n;
    prev_drv  = mem_dq_oe;
    prev_addr = mem_addr;
    prev_dout = mem_dq_o;
  end

  // Watchdog.
  int cyc_cnt = 0;
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual=%0d expected=<150000", cyc_cnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic op(input bit wr, input logic [16:0] a, input logic [7:0] d, input bit alter,
                    output logic [7:0] rd, output int k_rsp, output int k_rdy, output int n_rsp);
    int g;
    int k;
    g = 0;
    @(negedge clk);
    while (!req_ready && g < 100) begin @(negedge clk); g++; end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    chk(req_ready == 1'b0, "R2", "ready after accept", int'(req_ready), 0);
    if (alter) begin
      req_addr = a ^ 17'h00055; req_wdata = ~d; req_write = ~wr;
    end else begin
      req_valid = 1'b0;
    end
    k = 0; n_rsp = 0; k_rsp = -1; k_rdy = -1; rd = 8'h00;
    while (k < 60 && k_rdy < 0) begin
      @(negedge clk);
      k++;
      if (k == 1) req_valid = 1'b0;
      if (rsp_valid) begin n_rsp++; k_rsp = k; rd = rsp_rdata; end
      if (req_ready) k_rdy = k;
    end
  endtask

  task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit alter);
    logic [7:0] rd;
    int kr, ky, nr;
    op(1'b1, a, d, alter, rd, kr, ky, nr);
    refm[idx(a)] = d;
    chk(ky == 2 + e_wpul, "R9", "write cycles to ready", ky, 2 + e_wpul);
    chk(nr == 0, "R9", "rsp pulses on write", nr, 0);
  endtask

  task automatic do_read(input logic [16:0] a, input bit alter);
    logic [7:0] rd;
    int kr, ky, nr;
    op(1'b0, a, 8'h00, alter, rd, kr, ky, nr);
    chk(nr == 1, "R4", "rsp pulse count", nr, 1);
    chk(kr == E_RD, "R4", "cycles to rsp_valid", kr, E_RD);
    chk(ky == E_RD + e_turn, "R5", "read cycles to ready", ky, E_RD + e_turn);
    chk(rd == refm[idx(a)], "R3", "read data", int'(rd), int'(refm[idx(a)]));
  endtask

  initial begin
    logic [7:0] held;
    e_turn = cyc(T_OHZ);
    e_wpul = imax(imax(cyc(T_WP), cyc(T_WHZ) + cyc(T_DS)), imax(cyc(T_AW) - 1, 1));
    for (int i = 0; i < 512; i++) begin smem[i] = 8'h00; refm[i] = 8'h00; end
    void'($urandom(32'h1A2B3C4D));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk({mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe} == 5'b10110, "R1", "parked pins",
        int'({mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}), 'h16);

    chk(E_RD == 1 && e_turn == 1 && e_wpul == 2, "R11", "derived RD/TURN/WP",
        E_RD * 100 + e_turn * 10 + e_wpul, 112);

    // Boundary addresses.
    do_write(17'h00000, 8'hC3, 1'b0);
    do_write(17'h1FFFF, 8'h3C, 1'b0);
    do_read(17'h00000, 1'b0);
    do_read(17'h1FFFF, 1'b0);

    // Back-to-back write then read at one location.
    do_write(17'h00010, 8'hA7, 1'b0);
    do_read(17'h00010, 1'b0);

    // Fields changed while busy must have no effect (R2).
    do_write(17'h00020, 8'h11, 1'b1);
    do_read(17'h00020, 1'b0);
    do_read(17'h00020 ^ 17'h00055, 1'b0);
    chk(smem[idx(17'h00020 ^ 17'h00055)] == 8'h00, "R2", "altered address untouched",
        int'(smem[idx(17'h00020 ^ 17'h00055)]), 0);
    do_read(17'h00010, 1'b1);
    chk(smem[idx(17'h00010 ^ 17'h00055)] == 8'h00, "R2", "read-alter wrote nothing",
        int'(smem[idx(17'h00010 ^ 17'h00055)]), 0);

    // rsp_rdata holds across a write (R4).
    do_read(17'h1FFFF, 1'b0);
    held = rsp_rdata;
    do_write(17'h00030, 8'h99, 1'b0);
    chk(rsp_rdata == held, "R4", "rsp_rdata held after write", int'(rsp_rdata), int'(held));

    // Random mix.
    for (int n = 0; n < 300; n++) begin
      logic [16:0] a;
      logic [7:0]  lo;
      lo = 8'($urandom);
      a  = ($urandom % 2 == 1) ? {1'b1, 8'hFF, lo} : {9'h000, lo};
      if ($urandom % 2 == 1) do_write(a, 8'($urandom), 1'b0);
      else                   do_read(a, 1'b0);
    end

    repeat (4) @(negedge clk);
    chk(bad_park == 0, "R1", "cycles with ready but pins not parked", bad_park, 0);
    chk(bad_cont == 0, "R10", "cycles driving with oe_n low", bad_cont, 0);
    chk(bad_stab == 0, "R8", "address/data changes while active", bad_stab, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule